// File: doc/BRIEF.md
# Double frame buffer address switcher

This block holds two word-aligned frame-buffer base addresses for a capture DMA and decides which of them receives the next frame. It also keeps a sticky completion flag for each buffer. By default the choice flips as soon as a frame's DMA reports completion, so the two buffers alternate in lock-step with the transfers.

In event mode the flip happens on a chosen frame event instead: either the rising edge of vsync or the first-data pulse of a frame. The first such event after reset only opens the first frame and does not flip. Each later event flips the buffer. If no completion has arrived since the previous event, the flip is early, and a sticky error flag is raised.

All three flags are cleared by writing 1 through a clear vector. Each flag has its own interrupt enable, and these feed a single interrupt line.

Top module: `fbuf_base_switcher`

## Requirements
- R1: After reset, buffer 1 is selected (`cur_sel_o` = 0), all three status flags are 0 and `irq_o` is 0.
- R2: `cur_base_o` equals the selected word address (`base_a_i` when `cur_sel_o` = 0, `base_b_i` when 1) shifted left by two, with its two low bits always 0.
- R3: With `sw_evt_en_i` = 0, a `dma_done_i` pulse flips `cur_sel_o` on the next clock. Vsync and first-data have no effect on the selection.
- R4: A `dma_done_i` pulse sets `done_a_o` if buffer 1 is selected in that cycle, or `done_b_o` if buffer 2 is selected.
- R5: With `sw_evt_en_i` = 1 and `sw_evt_sel_i` = 0, the trigger is a rising edge of `vsync_i`, and `first_data_i` is ignored.
- R6: With `sw_evt_en_i` = 1 and `sw_evt_sel_i` = 1, the trigger is a `first_data_i` pulse, and `vsync_i` is ignored.
- R7: In event mode, `dma_done_i` does not change the selection. Every trigger after the first one since reset flips it.
- R8: In event mode, a trigger after the first one sets `err_o` if no `dma_done_i` has arrived since the previous trigger. A `dma_done_i` in the same cycle as the trigger counts as arriving first, so no error is raised.
- R9: The first trigger after reset neither flips the selection nor raises an error.
- R10: `clr_i` clears flags by writing 1: bit 0 clears `done_a_o`, bit 1 clears `done_b_o` and bit 2 clears `err_o`. A set in the same cycle wins over a clear.
- R11: `irq_o` is the OR of (`done_a_o` AND `irq_en_i[0]`), (`done_b_o` AND `irq_en_i[1]`) and (`err_o` AND `irq_en_i[2]`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_a_i | input | 30 | Buffer 1 word address (byte address bits 31:2) |
| base_b_i | input | 30 | Buffer 2 word address (byte address bits 31:2) |
| sw_evt_en_i | input | 1 | 1 selects event-driven switching |
| sw_evt_sel_i | input | 1 | Event choice: 0 = vsync rising edge, 1 = first data |
| vsync_i | input | 1 | Frame sync level |
| first_data_i | input | 1 | Pulse on the first data beat of a frame |
| dma_done_i | input | 1 | Pulse when the current frame's DMA completes |
| clr_i | input | 3 | Write-1-to-clear for {error, buffer 2 done, buffer 1 done} |
| irq_en_i | input | 3 | Interrupt enables, same bit order as `clr_i` |
| cur_base_o | output | 32 | Byte base address of the selected buffer |
| cur_sel_o | output | 1 | Selected buffer: 0 = buffer 1, 1 = buffer 2 |
| done_a_o | output | 1 | Buffer 1 transfer done flag |
| done_b_o | output | 1 | Buffer 2 transfer done flag |
| err_o | output | 1 | Premature switch error flag |
| irq_o | output | 1 | Interrupt line |

## Verification
The hardest cases to reach are the premature-switch error and its exemption. Reaching them needs an armed frame, then two triggers with no completion between them, and then a trigger that coincides with a completion. A plain vsync level is not enough, because only a fresh rising edge counts as a trigger.

The stimulus is a pseudo-random sequence with a fixed seed, run once in each of the three switching modes, each run starting from reset. The sequence freely mixes vsync toggles, first-data pulses, completions, clears and enable patterns. A small reference model in the bench predicts every output after every cycle. Short directed runs pin down the arming trigger and a set that coincides with a clear.

// File: rtl/fbsw_pkg.sv
package fbsw_pkg;

  localparam int unsigned STAT_N    = 3;
  localparam int unsigned STAT_DA   = 0;
  localparam int unsigned STAT_DB   = 1;
  localparam int unsigned STAT_ERR  = 2;

  typedef logic [STAT_N-1:0] stat_vec_t;

  // sticky flag update: set has priority over a write-1 clear
  function automatic logic sticky_next(input logic cur, input logic set,
                                       input logic clr);
    return set | (cur & ~clr);
  endfunction

  // interrupt reduction of flags against enables
  function automatic logic irq_reduce(input stat_vec_t flags,
                                      input stat_vec_t enables);
    return |(flags & enables);
  endfunction

endpackage

// File: rtl/fbsw_trigger.sv
module fbsw_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_en_i,
  input  logic evt_sel_i,
  input  logic vsync_i,
  input  logic first_data_i,
  output logic vsync_rise_o,
  output logic trig_o
);

  logic vsync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vsync_q <= 1'b0;
    else        vsync_q <= vsync_i;
  end

  assign vsync_rise_o = vsync_i & ~vsync_q;
  assign trig_o       = evt_en_i & (evt_sel_i ? first_data_i : vsync_rise_o);

endmodule

// File: rtl/fbsw_sel_ctrl.sv
module fbsw_sel_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_en_i,
  input  logic trig_i,
  input  logic dma_done_i,
  output logic sel_o,
  output logic swap_o,
  output logic premature_o
);

  logic sel_q;
  logic armed_q;     // a frame has been opened since reset
  logic seen_q;      // completion seen since the last trigger

  assign swap_o      = evt_en_i ? (trig_i & armed_q) : dma_done_i;
  assign premature_o = evt_en_i & trig_i & armed_q & ~seen_q & ~dma_done_i;
  assign sel_o       = sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      armed_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      if (swap_o) sel_q <= ~sel_q;
      if (trig_i) begin
        armed_q <= 1'b1;
        seen_q  <= 1'b0;
      end else if (dma_done_i) begin
        seen_q  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fbsw_status.sv
module fbsw_status
  import fbsw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  stat_vec_t set_i,
  input  stat_vec_t clr_i,
  input  stat_vec_t ie_i,
  output stat_vec_t stat_o,
  output logic      irq_o
);

  stat_vec_t stat_q;

  for (genvar g = 0; g < STAT_N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[g] <= 1'b0;
      else        stat_q[g] <= sticky_next(stat_q[g], set_i[g], clr_i[g]);
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = irq_reduce(stat_q, ie_i);

endmodule

// File: rtl/fbuf_base_switcher.sv
module fbuf_base_switcher
  import fbsw_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-ALIGN_BITS-1:0] base_a_i,
  input  logic [ADDR_W-ALIGN_BITS-1:0] base_b_i,
  input  logic                         sw_evt_en_i,
  input  logic                         sw_evt_sel_i,
  input  logic                         vsync_i,
  input  logic                         first_data_i,
  input  logic                         dma_done_i,
  input  logic [STAT_N-1:0]            clr_i,
  input  logic [STAT_N-1:0]            irq_en_i,
  output logic [ADDR_W-1:0]            cur_base_o,
  output logic                         cur_sel_o,
  output logic                         done_a_o,
  output logic                         done_b_o,
  output logic                         err_o,
  output logic                         irq_o
);

  localparam int unsigned WORD_W = ADDR_W - ALIGN_BITS;

  logic      vsync_rise_w;
  logic      trig_w;
  logic      swap_w;
  logic      premature_w;
  logic      sel_w;
  stat_vec_t set_w;
  stat_vec_t stat_w;
  logic [WORD_W-1:0] word_w;

  fbsw_trigger u_trig (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_en_i     (sw_evt_en_i),
    .evt_sel_i    (sw_evt_sel_i),
    .vsync_i      (vsync_i),
    .first_data_i (first_data_i),
    .vsync_rise_o (vsync_rise_w),
    .trig_o       (trig_w)
  );

  fbsw_sel_ctrl u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_en_i    (sw_evt_en_i),
    .trig_i      (trig_w),
    .dma_done_i  (dma_done_i),
    .sel_o       (sel_w),
    .swap_o      (swap_w),
    .premature_o (premature_w)
  );

  always_comb begin
    set_w           = '0;
    set_w[STAT_DA]  = dma_done_i & ~sel_w;
    set_w[STAT_DB]  = dma_done_i &  sel_w;
    set_w[STAT_ERR] = premature_w;
  end

  fbsw_status u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_w),
    .clr_i  (clr_i),
    .ie_i   (irq_en_i),
    .stat_o (stat_w),
    .irq_o  (irq_o)
  );

  assign word_w = sel_w ? base_b_i : base_a_i;

  if (ALIGN_BITS > 0) begin : g_align
    assign cur_base_o = {word_w, {ALIGN_BITS{1'b0}}};
  end else begin : g_noalign
    assign cur_base_o = word_w;
  end

  assign cur_sel_o = sel_w;
  assign done_a_o  = stat_w[STAT_DA];
  assign done_b_o  = stat_w[STAT_DB];
  assign err_o     = stat_w[STAT_ERR];

endmodule

// File: rtl/fbsw_checker.sv
module fbsw_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_evt_en_i,
  input logic       dma_done_i,
  input logic [2:0] clr_i,
  input logic [2:0] irq_en_i,
  input logic       cur_sel_o,
  input logic       done_a_o,
  input logic       done_b_o,
  input logic       err_o,
  input logic       irq_o,
  input logic       swap_w,
  input logic       premature_w
);

  // R3
  auto_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_evt_en_i && dma_done_i) |=> (cur_sel_o != $past(cur_sel_o)));

  // R7
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_evt_en_i && !swap_w) |=> $stable(cur_sel_o));

  // R4
  done_a_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_done_i && !cur_sel_o) |=> done_a_o);

  // R4
  done_b_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_done_i && cur_sel_o) |=> done_b_o);

  // R8
  premature_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    premature_w |=> err_o);

  // R10
  clr_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i[0] && !(dma_done_i && !cur_sel_o)) |=> !done_a_o);

  // R10
  clr_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i[1] && !(dma_done_i && cur_sel_o)) |=> !done_b_o);

  // R10
  clr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i[2] && !premature_w) |=> !err_o);

  // R11
  irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ((done_a_o & irq_en_i[0]) | (done_b_o & irq_en_i[1]) |
              (err_o & irq_en_i[2])));

endmodule

bind fbuf_base_switcher fbsw_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sw_evt_en_i (sw_evt_en_i),
  .dma_done_i  (dma_done_i),
  .clr_i       (clr_i),
  .irq_en_i    (irq_en_i),
  .cur_sel_o   (cur_sel_o),
  .done_a_o    (done_a_o),
  .done_b_o    (done_b_o),
  .err_o       (err_o),
  .irq_o       (irq_o),
  .swap_w      (swap_w),
  .premature_w (premature_w)
);

// File: tb/fbuf_base_switcher_bench.sv
`timescale 1ns/1ps
module fbuf_base_switcher_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [29:0] base_a, base_b;
  logic        evt_en, evt_sel, vsync, fdata, done;
  logic [2:0]  clr, ie;
  logic [31:0] cur_base;
  logic        cur_sel, da, db, err, irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference model state
  bit m_sel, m_armed, m_seen, m_da, m_db, m_err, m_vprev;

  always #2 clk = ~clk;

  fbuf_base_switcher u_fbuf_base_switcher (
    .clk(clk), .rst_n(rst_n), .base_a_i(base_a), .base_b_i(base_b),
    .sw_evt_en_i(evt_en), .sw_evt_sel_i(evt_sel), .vsync_i(vsync),
    .first_data_i(fdata), .dma_done_i(done), .clr_i(clr), .irq_en_i(ie),
    .cur_base_o(cur_base), .cur_sel_o(cur_sel), .done_a_o(da),
    .done_b_o(db), .err_o(err), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit e, input bit s);
    @(negedge clk);
    rst_n = 1'b0; evt_en = e; evt_sel = s;
    vsync = 0; fdata = 0; done = 0; clr = 0; ie = 0;
    m_sel = 0; m_armed = 0; m_seen = 0; m_da = 0; m_db = 0; m_err = 0;
    m_vprev = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one cycle: drive at negedge, advance model, check at the next negedge
  task automatic step(input bit v, input bit f, input bit d,
                      input logic [2:0] c, input logic [2:0] en,
                      input string sel_tag);
    bit trig, sa, sb, se, exp_irq;
    vsync = v; fdata = f; done = d; clr = c; ie = en;
    trig = evt_en && (evt_sel ? f : (v && !m_vprev));
    sa = d && !m_sel;
    sb = d && m_sel;
    se = trig && m_armed && !m_seen && !d;
    m_da  = sa || (m_da  && !c[0]);
    m_db  = sb || (m_db  && !c[1]);
    m_err = se || (m_err && !c[2]);
    if (evt_en ? (trig && m_armed) : d) m_sel = !m_sel;
    if (trig) begin m_armed = 1; m_seen = 0; end
    else if (d) m_seen = 1;
    m_vprev = v;
    @(posedge clk);
    @(negedge clk);
    exp_irq = (m_da && en[0]) || (m_db && en[1]) || (m_err && en[2]);
    chk(sel_tag, {31'b0, cur_sel}, {31'b0, m_sel});
    chk("R2", cur_base, {(m_sel ? base_b : base_a), 2'b00});
    chk("R4 R10 done_a", {31'b0, da}, {31'b0, m_da});
    chk("R4 R10 done_b", {31'b0, db}, {31'b0, m_db});
    chk("R8 R10 err", {31'b0, err}, {31'b0, m_err});
    chk("R11", {31'b0, irq}, {31'b0, exp_irq});
  endtask

  task automatic sweep(input bit e, input bit s, input string tag);
    logic [15:0] r = 16'hACE1;
    do_reset(e, s);
    for (int i = 0; i < 400; i++) begin
      logic [2:0] c;
      c = (r[6] & r[7] & r[8]) ? r[11:9] : 3'b000;
      step(r[1], r[2] & r[3], r[4] & r[5], c, r[14:12], tag);
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
    end
  endtask

  initial begin
    base_a = 30'h0ABC_1234;
    base_b = 30'h1357_9BDF;
    rst_n  = 1'b0;

    // R1: reset state
    do_reset(0, 0);
    @(negedge clk);
    chk("R1 sel", {31'b0, cur_sel}, 32'd0);
    chk("R1 flags", {29'b0, err, db, da}, 32'd0);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R2 reset base", cur_base, {base_a, 2'b00});

    // R9: arming trigger neither swaps nor errors; R5 vsync edge
    do_reset(1, 0);
    step(1, 0, 0, 3'b000, 3'b111, "R9 arm");
    step(1, 0, 0, 3'b000, 3'b111, "R5 level held");
    step(0, 0, 0, 3'b000, 3'b111, "R5");
    step(1, 0, 0, 3'b000, 3'b111, "R8 premature swap");
    chk("R8 directed err", {31'b0, err}, 32'd1);
    step(0, 0, 1, 3'b100, 3'b000, "R7 done no swap");
    step(1, 0, 1, 3'b000, 3'b000, "R8 coincident");
    chk("R8 coincident no err", {31'b0, err}, 32'd0);

    // R10: set wins over clear in the same cycle
    do_reset(0, 0);
    step(0, 0, 1, 3'b001, 3'b001, "R3 R10 set wins");
    chk("R10 set wins", {31'b0, da}, 32'd1);

    // R6: first-data trigger, vsync ignored
    do_reset(1, 1);
    step(0, 1, 0, 3'b000, 3'b000, "R9 arm fd");
    step(1, 0, 0, 3'b000, 3'b000, "R6 vsync ignored");
    step(0, 1, 1, 3'b000, 3'b000, "R6 fd swap");
    chk("R6 swapped", {31'b0, cur_sel}, 32'd1);

    sweep(0, 0, "R3 auto");
    sweep(1, 0, "R5 R7 vsync");
    sweep(1, 1, "R6 R7 first-data");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule